// File: doc/BRIEF.md
# Two-Stream Random Linear Payload Coder

This block merges two word-aligned 64-bit payload streams into one output stream. Each stream is read from a show-ahead FIFO. A FIFO presents its head word, an end-of-packet marker and an empty flag, and the block pulses a read strobe to pop it. When a packet starts and both FIFOs hold data, the block draws two fresh 8-bit coefficients from an internal 16-bit LFSR. It then reads the two streams in lockstep. For each pair it forms `a*ca + b*cb` modulo 2^72 and passes the 72-bit sums through a width converter that produces 64-bit words. When only one FIFO holds data at the start of a packet, that packet is forwarded word for word without coding.

Every output word is 73 bits wide and is written with a one-cycle write strobe. A word is produced only in a cycle in which the downstream ready input was high. Bit 64 marks the word as coded (1) or uncoded (0). The two coefficients of the current coded packet and the 3-bit controller state are brought out so that downstream packing logic can tag the packet.

The controller has seven named states:

| State | Code | Role |
|-------|------|------|
| IDLE | 0 | Wait for a packet. |
| DRAW_A | 1 | Load the first coefficient. |
| DRAW_B | 2 | Load the second coefficient. |
| CODE | 3 | Read word pairs and push the coded sums. |
| FLUSH | 4 | Emit the remaining bits of the width converter. |
| PASS_A | 5 | Forward stream A uncoded. |
| PASS_B | 6 | Forward stream B uncoded. |

The transitions are as follows:
- IDLE goes to DRAW_A when both FIFOs are non-empty.
- IDLE goes to PASS_A when only A is non-empty, and to PASS_B when only B is non-empty.
- DRAW_A always goes to DRAW_B, and DRAW_B always goes to CODE.
- CODE goes to FLUSH after it consumes the pair that carries end-of-packet.
- FLUSH goes to IDLE after it emits the remaining bits, or at once if none remain.
- PASS_A and PASS_B go to IDLE after they forward the end-of-packet word.

Top module: `rlc_coder`

## Requirements
- R1: After reset `out_we` is 0, `mode` is 0 (IDLE), both coefficients are 0 and neither read strobe is asserted.
- R2: When only stream A holds data at packet start, each A word is written once, in order, as `{8'b0, 1'b0, word}`, and no B word is read.
- R3: When only stream B holds data at packet start, each B word is written once, in order, as `{8'b0, 1'b0, word}`, and no A word is read.
- R4: A packet that starts with both FIFOs non-empty is coded. Its coefficients are the low byte of the LFSR state (taps 16, 14, 13 and 11, seed 0xACE1, shifting left with the feedback bit entering at bit 0). The first byte goes to `coef_a` and the next to `coef_b`. The generator advances exactly twice per coded packet, and the coefficients stay fixed between draws.
- R5: Each coded pair forms `a*coef_a + b*coef_b` truncated to 72 bits, so any carry out of bit 71 is lost.
- R6: The 72-bit sums of a coded packet of n pairs are concatenated LSB-first. They are written as ceil(72n/64) words of `{8'b0, 1'b1, bits}`, and the final word is zero-filled above the last valid bit.
- R7: While `out_ready` is low nothing is read. `out_we` stays low in the following cycle, and no data is lost.
- R8: `mode` shows the state code from the table above and never exceeds 6.
- R9: In CODE both streams are read in the same cycle or not at all. If either FIFO runs empty mid-packet, the block waits without losing data.
- R10: A FIFO whose empty flag is set is never read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_data | input | 64 | Head word of FIFO A |
| a_eop | input | 1 | Head word of A ends its packet |
| a_empty | input | 1 | FIFO A holds no word |
| a_rd | output | 1 | Pop FIFO A |
| b_data | input | 64 | Head word of FIFO B |
| b_eop | input | 1 | Head word of B ends its packet |
| b_empty | input | 1 | FIFO B holds no word |
| b_rd | output | 1 | Pop FIFO B |
| out_word | output | 73 | Output word; bit 64 is the coded flag |
| out_we | output | 1 | `out_word` is valid this cycle |
| out_ready | input | 1 | Downstream can take a word |
| mode | output | 3 | Controller state code |
| coef_a | output | 8 | Coefficient applied to stream A |
| coef_b | output | 8 | Coefficient applied to stream B |

## Verification
Single-stream packets on A and then on B show that the bypass is selected by FIFO occupancy and forwards the correct stream with flag 0. Coded packets of 1, 3, 8 and 9 pairs probe the width converter:
- 1 pair gives a flush word holding 8 valid bits.
- 8 pairs give a full ninth word with no further input.
- 9 pairs need an extra drain word in the middle of the packet.

An all-ones packet makes the 72-bit sum overflow, which exposes any carry that is kept. Toggling ready on every cycle, holding ready low, and starving stream B mid-packet each show whether a stall loses, repeats or misaligns words.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DRAW_A = 3'd1,
        ST_DRAW_B = 3'd2,
        ST_CODE   = 3'd3,
        ST_FLUSH  = 3'd4,
        ST_PASS_A = 3'd5,
        ST_PASS_B = 3'd6
    } rlc_state_e;

    localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/rlc_lfsr.sv
// Fibonacci LFSR shifting left; the low CW bits form a coefficient.
module rlc_lfsr #(
    parameter int unsigned LW = 16,
    parameter int unsigned CW = 8,
    parameter logic [LW-1:0] SEED = 16'hACE1,
    parameter logic [LW-1:0] TAPS = 16'hB400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] low
);

    logic [LW-1:0] q;
    logic          fb;

    assign fb  = ^(q & TAPS);
    assign low = q[CW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (step) begin
            q <= {q[LW-2:0], fb};
        end
    end

endmodule

// File: rtl/rlc_mac.sv
// Two-lane multiply and sum, all arithmetic modulo 2^(DW+CW).
module rlc_mac #(
    parameter int unsigned DW = 64,
    parameter int unsigned CW = 8
) (
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [CW-1:0]    ca,
    input  logic [CW-1:0]    cb,
    output logic [DW+CW-1:0] sum
);

    localparam int unsigned PW = DW + CW;

    logic [PW-1:0] prod [2];
    logic [DW-1:0] lane_d [2];
    logic [CW-1:0] lane_c [2];

    assign lane_d[0] = a;
    assign lane_d[1] = b;
    assign lane_c[0] = ca;
    assign lane_c[1] = cb;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign prod[g] = PW'(lane_d[g]) * PW'(lane_c[g]);
    end

    assign sum = prod[0] + prod[1];

endmodule

// File: rtl/rlc_gearbox.sv
// Packs PW-bit words LSB-first into DW-bit words. A push always emits one
// word; once DW bits are left over, the owner must drain before pushing.
module rlc_gearbox #(
    parameter int unsigned DW = 64,
    parameter int unsigned CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW+CW-1:0] in_word,
    input  logic             drain,
    output logic [DW-1:0]    word,
    output logic             full,
    output logic             empty
);

    localparam int unsigned WW   = 2 * DW;
    localparam int unsigned CNTW = $clog2(DW + 1);

    logic [DW-1:0]   res;
    logic [CNTW-1:0] cnt;
    logic [WW-1:0]   wide;

    assign wide  = {{DW{1'b0}}, res} | (WW'(in_word) << cnt);
    assign word  = push ? wide[DW-1:0] : res;
    assign full  = (cnt == CNTW'(DW));
    assign empty = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res <= '0;
            cnt <= '0;
        end else if (push) begin
            res <= wide[WW-1:DW];
            cnt <= cnt + CNTW'(CW);
        end else if (drain) begin
            res <= '0;
            cnt <= '0;
        end
    end

endmodule

// File: rtl/rlc_coder.sv
module rlc_coder
    import rlc_pkg::*;
#(
    parameter int unsigned DW = 64,
    parameter int unsigned CW = 8,
    parameter int unsigned LW = 16,
    parameter logic [LW-1:0] SEED = 16'hACE1,
    parameter logic [LW-1:0] TAPS = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    a_data,
    input  logic             a_eop,
    input  logic             a_empty,
    output logic             a_rd,
    input  logic [DW-1:0]    b_data,
    input  logic             b_eop,
    input  logic             b_empty,
    output logic             b_rd,
    output logic [DW+CW:0]   out_word,
    output logic             out_we,
    input  logic             out_ready,
    output logic [2:0]       mode,
    output logic [CW-1:0]    coef_a,
    output logic [CW-1:0]    coef_b
);

    localparam int unsigned OW = DW + CW + 1;
    localparam int unsigned PW = DW + CW;

    rlc_state_e state, nxt;

    logic          both_ready;
    logic          lf_step, load_a, load_b;
    logic          gb_push, gb_drain, gb_full, gb_empty;
    logic          emit, emit_coded, sel_b;
    logic [CW-1:0] lf_low;
    logic [PW-1:0] mac_sum;
    logic [DW-1:0] gb_word;
    logic [OW-1:0] word_d;

    assign both_ready = !a_empty && !b_empty;
    assign mode       = state;

    rlc_lfsr #(.LW(LW), .CW(CW), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (lf_step),
        .low   (lf_low)
    );

    rlc_mac #(.DW(DW), .CW(CW)) u_mac (
        .a   (a_data),
        .b   (b_data),
        .ca  (coef_a),
        .cb  (coef_b),
        .sum (mac_sum)
    );

    rlc_gearbox #(.DW(DW), .CW(CW)) u_gear (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (gb_push),
        .in_word (mac_sum),
        .drain   (gb_drain),
        .word    (gb_word),
        .full    (gb_full),
        .empty   (gb_empty)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (both_ready) begin
                    nxt = ST_DRAW_A;
                end else if (!a_empty) begin
                    nxt = ST_PASS_A;
                end else if (!b_empty) begin
                    nxt = ST_PASS_B;
                end
            end
            ST_DRAW_A: nxt = ST_DRAW_B;
            ST_DRAW_B: nxt = ST_CODE;
            ST_CODE: begin
                if (out_ready && !gb_full && both_ready && (a_eop || b_eop)) begin
                    nxt = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (gb_empty || out_ready) begin
                    nxt = ST_IDLE;
                end
            end
            ST_PASS_A: begin
                if (out_ready && !a_empty && a_eop) begin
                    nxt = ST_IDLE;
                end
            end
            ST_PASS_B: begin
                if (out_ready && !b_empty && b_eop) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Per-state actions
    always_comb begin
        a_rd       = 1'b0;
        b_rd       = 1'b0;
        lf_step    = 1'b0;
        load_a     = 1'b0;
        load_b     = 1'b0;
        gb_push    = 1'b0;
        gb_drain   = 1'b0;
        emit       = 1'b0;
        emit_coded = 1'b0;
        sel_b      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_DRAW_A: begin
                load_a  = 1'b1;
                lf_step = 1'b1;
            end
            ST_DRAW_B: begin
                load_b  = 1'b1;
                lf_step = 1'b1;
            end
            ST_CODE: begin
                if (out_ready) begin
                    if (gb_full) begin
                        gb_drain   = 1'b1;
                        emit       = 1'b1;
                        emit_coded = 1'b1;
                    end else if (both_ready) begin
                        a_rd       = 1'b1;
                        b_rd       = 1'b1;
                        gb_push    = 1'b1;
                        emit       = 1'b1;
                        emit_coded = 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                if (out_ready && !gb_empty) begin
                    gb_drain   = 1'b1;
                    emit       = 1'b1;
                    emit_coded = 1'b1;
                end
            end
            ST_PASS_A: begin
                if (out_ready && !a_empty) begin
                    a_rd = 1'b1;
                    emit = 1'b1;
                end
            end
            ST_PASS_B: begin
                if (out_ready && !b_empty) begin
                    b_rd  = 1'b1;
                    emit  = 1'b1;
                    sel_b = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign word_d = emit_coded ? {{CW{1'b0}}, 1'b1, gb_word}
                               : {{CW{1'b0}}, 1'b0, (sel_b ? b_data : a_data)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word <= '0;
            out_we   <= 1'b0;
            coef_a   <= '0;
            coef_b   <= '0;
        end else begin
            out_we <= emit;
            if (emit) begin
                out_word <= word_d;
            end
            if (load_a) begin
                coef_a <= lf_low;
            end
            if (load_b) begin
                coef_b <= lf_low;
            end
        end
    end

endmodule

// File: rtl/rlc_coder_chk.sv
module rlc_coder_chk
    import rlc_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_empty,
    input logic          a_rd,
    input logic          b_empty,
    input logic          b_rd,
    input logic [CW-1:0] out_spare,
    input logic          out_we,
    input logic          out_ready,
    input logic [2:0]    mode,
    input logic [CW-1:0] coef_a,
    input logic [CW-1:0] coef_b
);

    assert_no_read_empty_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd |-> !a_empty);
    assert_no_read_empty_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        b_rd |-> !b_empty);
    assert_paired_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_CODE) |-> (a_rd == b_rd));
    assert_no_read_unready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> (!a_rd && !b_rd));
    assert_no_write_unready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |=> !out_we);
    assert_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> (out_spare == '0));
    assert_pass_a_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_PASS_A) |-> !b_rd);
    assert_pass_b_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_PASS_B) |-> !a_rd);
    assert_coef_a_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != ST_DRAW_A) |=> $stable(coef_a));
    assert_coef_b_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != ST_DRAW_B) |=> $stable(coef_b));
    assert_mode_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode <= 3'd6);

endmodule

bind rlc_coder rlc_coder_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_empty   (a_empty),
    .a_rd      (a_rd),
    .b_empty   (b_empty),
    .b_rd      (b_rd),
    .out_spare (out_word[DW+CW:DW+1]),
    .out_we    (out_we),
    .out_ready (out_ready),
    .mode      (mode),
    .coef_a    (coef_a),
    .coef_b    (coef_b)
);

// File: tb/rlc_coder_test.sv
module rlc_coder_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a_data, b_data;
    logic        a_eop, b_eop, a_empty, b_empty, a_rd, b_rd;
    logic [72:0] out_word;
    logic        out_we;
    logic        out_ready = 1'b1;
    logic [2:0]  mode;
    logic [7:0]  coef_a, coef_b;

    int n_vec = 0;
    int n_fail = 0;

    // Bench FIFOs: show-ahead, entry = {eop, data}
    logic [64:0] mem_a [0:255];
    logic [64:0] mem_b [0:255];
    logic [7:0]  a_head, b_head;
    logic [7:0]  a_tail = 8'd0;
    logic [7:0]  b_tail = 8'd0;

    assign a_empty = (a_head == a_tail);
    assign b_empty = (b_head == b_tail);
    assign a_data  = mem_a[a_head][63:0];
    assign a_eop   = mem_a[a_head][64];
    assign b_data  = mem_b[b_head][63:0];
    assign b_eop   = mem_b[b_head][64];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_head <= 8'd0;
            b_head <= 8'd0;
        end else begin
            if (a_rd) a_head <= a_head + 8'd1;
            if (b_rd) b_head <= b_head + 8'd1;
        end
    end

    // Capture of written words, sampled away from the clock edge
    logic [72:0] cap [0:1023];
    int cap_n = 0;
    always @(negedge clk) begin
        if (out_we) begin
            cap[cap_n] = out_word;
            cap_n = cap_n + 1;
        end
    end

    logic [15:0] lf_model = 16'hACE1;

    rlc_coder uut (
        .clk(clk), .rst_n(rst_n),
        .a_data(a_data), .a_eop(a_eop), .a_empty(a_empty), .a_rd(a_rd),
        .b_data(b_data), .b_eop(b_eop), .b_empty(b_empty), .b_rd(b_rd),
        .out_word(out_word), .out_we(out_we), .out_ready(out_ready),
        .mode(mode), .coef_a(coef_a), .coef_b(coef_b)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] lf_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [63:0] gen(input logic [31:0] sd, input int k);
        logic [31:0] kk;
        kk = 32'(k);
        return {sd ^ (kk * 32'h9E3779B9), ~sd + kk * 32'h01000193};
    endfunction

    task automatic check(input string req, input logic [72:0] act, input logic [72:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_a(input logic [63:0] d, input logic e);
        mem_a[a_tail] = {e, d};
        a_tail = a_tail + 8'd1;
    endtask

    task automatic push_b(input logic [63:0] d, input logic e);
        mem_b[b_tail] = {e, d};
        b_tail = b_tail + 8'd1;
    endtask

    task automatic wait_idle(input string req, input bit choppy);
        int guard = 0;
        do begin
            @(negedge clk);
            if (choppy) out_ready = ~out_ready;
            guard++;
        end while (!(a_empty && b_empty && mode == 3'd0) && guard < 4000);
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        if (guard >= 4000) check({req, " timeout"}, 73'd1, 73'd0);
    endtask

    task automatic t_reset();
        check("R1 out_we", 73'(out_we), 73'd0);
        check("R1 mode", 73'(mode), 73'd0);
        check("R1 coef_a", 73'(coef_a), 73'd0);
        check("R1 coef_b", 73'(coef_b), 73'd0);
        check("R1 reads", 73'({a_rd, b_rd}), 73'd0);
    endtask

    task automatic t_pass(input bit on_b, input int n, input logic [31:0] sd, input bit stall);
        logic [63:0] d [0:15];
        int start = cap_n;
        string req = on_b ? "R3" : "R2";
        if (stall) out_ready = 1'b0;
        for (int k = 0; k < n; k++) begin
            d[k] = gen(sd, k);
            if (on_b) push_b(d[k], k == n - 1);
            else      push_a(d[k], k == n - 1);
        end
        if (stall) begin
            repeat (6) @(negedge clk);
            check("R7 no write", 73'(cap_n - start), 73'd0);
            check("R7 no read", 73'(a_tail - a_head), 73'(n));
            check("R8 mode PASS_A", 73'(mode), 73'd5);
            out_ready = 1'b1;
        end
        wait_idle(req, 1'b0);
        check({req, " count"}, 73'(cap_n - start), 73'(n));
        for (int k = 0; k < n; k++)
            check({req, " word"}, cap[start + k], {8'd0, 1'b0, d[k]});
    endtask

    // gap > 0: B gets only `gap` words first, the rest after a pause
    task automatic t_code(input string req, input int n, input logic [31:0] sd,
                          input bit ones, input bit choppy, input int gap);
        logic [63:0]   da [0:15];
        logic [63:0]   db [0:15];
        logic [1023:0] strm;
        logic [71:0]   s72;
        logic [7:0]    ca, cb;
        int start = cap_n;
        int nw;
        ca = lf_model[7:0];
        lf_model = lf_next(lf_model);
        cb = lf_model[7:0];
        lf_model = lf_next(lf_model);
        strm = '0;
        for (int k = 0; k < n; k++) begin
            da[k] = ones ? 64'hFFFF_FFFF_FFFF_FFFF : gen(sd, k);
            db[k] = ones ? 64'hFFFF_FFFF_FFFF_FFFF : gen(~sd, k + 7);
            s72 = 72'(da[k]) * 72'(ca) + 72'(db[k]) * 72'(cb);
            strm[k * 72 +: 72] = s72;
            push_a(da[k], k == n - 1);
            if (gap == 0 || k < gap) push_b(db[k], k == n - 1);
        end
        if (gap > 0) begin
            repeat (12) @(negedge clk);
            check("R9 stalled count", 73'(cap_n - start), 73'(gap));
            check("R9 mode CODE", 73'(mode), 73'd3);
            for (int k = gap; k < n; k++) push_b(db[k], k == n - 1);
        end
        wait_idle(req, choppy);
        nw = (72 * n + 63) / 64;
        check("R4 coef_a", 73'(coef_a), 73'(ca));
        check("R4 coef_b", 73'(coef_b), 73'(cb));
        check("R6 count", 73'(cap_n - start), 73'(nw));
        for (int w = 0; w < nw; w++)
            check({req, " word"}, cap[start + w], {8'd0, 1'b1, strm[w * 64 +: 64]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();                                        // R1
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();                                        // R1 still idle
        t_pass(1'b0, 4, 32'h1111_0000, 1'b0);             // R2
        t_pass(1'b1, 3, 32'h2222_0000, 1'b0);             // R3
        t_pass(1'b0, 3, 32'h3333_0000, 1'b1);             // R7 stall, R8
        t_code("R5", 3, 32'hC0DE_0001, 1'b0, 1'b0, 0);    // R4 R5 R6
        t_code("R6", 1, 32'hC0DE_0002, 1'b0, 1'b0, 0);    // 8-bit flush word
        t_code("R6", 8, 32'hC0DE_0003, 1'b0, 1'b0, 0);    // full ninth word
        t_code("R6", 9, 32'hC0DE_0004, 1'b0, 1'b0, 0);    // mid-packet drain
        t_code("R5", 2, 32'h0, 1'b1, 1'b0, 0);            // carry out dropped
        t_code("R7", 9, 32'hC0DE_0005, 1'b0, 1'b1, 0);    // ready toggling
        t_code("R9", 4, 32'hC0DE_0006, 1'b0, 1'b0, 2);    // B starved
        t_pass(1'b1, 2, 32'h4444_0000, 1'b0);             // R3 after coding
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule